// File: doc/BRIEF.md
# CAN Overload Frame Trigger

This block sits beside a CAN protocol engine and decides when an overload frame has to go out. It watches a frame-position code, the sampled bus level and a one-cycle sample-point strobe. When a dominant level shows up at one of the positions that call for a reactive overload, or when a request overload is pending after a mailbox reception, it arms itself. At the next bit boundary it fires a one-cycle start pulse toward the transmit path. It then holds an overload-flag-active indication for the length of the flag.

While the overload flag is being started or driven, the block masks the error-counter increment requests that pass through it. This keeps the receive and transmit error counters unchanged for overload flags. A pending overload is discarded if the node goes bus-off or the controller is disabled before the overload can start.

Top module: `can_ovld_trigger`

## Requirements
- R1: A dominant level (rx_bit = 0) sampled while pos is 2 (first intermission bit) or 3 (second intermission bit) produces an ovl_start pulse at the next bit_start.
- R2: A dominant level sampled while pos is 1 (last end-of-frame bit) produces an ovl_start at the next bit_start only when is_rx is 1, and never when is_rx is 0.
- R3: A dominant level sampled while pos is 5 (last error-delimiter bit) or 6 (last overload-delimiter bit) produces an ovl_start at the next bit_start, whatever the value of is_rx.
- R4: A dominant level sampled while pos is 4 (third intermission bit) produces no ovl_start.
- R5: With req_en at 1, an mbox_rx_done pulse makes the block issue an ovl_start at the first bit_start after a sample point with pos 1. The level at that point does not matter. With req_en at 0, the pulse has no effect.
- R6: The reactive triggers of R1 to R3 work with req_en at 0.
- R7: Triggers are evaluated only on cycles where sample_pt is 1. ovl_start lasts exactly one cycle and occurs only in a cycle where bit_start is 1.
- R8: ovl_active rises in the cycle after ovl_start and stays high for FLAG_BITS bit_start pulses. Trigger conditions seen while it is high start no new overload.
- R9: err_inc_rx and err_inc_tx follow err_inc_rx_req and err_inc_tx_req, except that both are 0 while ovl_start or ovl_active is 1.
- R10: If bus_off is 1 or ctrl_en is 0 for any cycle, any pending or armed overload is dropped, and the following bit_start gives no ovl_start.
- R11: After reset, ovl_start, ovl_active, err_inc_rx and err_inc_tx are 0 while the increment requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_pt | input | 1 | One-cycle strobe at the sample point of a bit |
| bit_start | input | 1 | One-cycle strobe at the start of a bit |
| rx_bit | input | 1 | Sampled bus level, 0 dominant |
| pos | input | 3 | Frame position code of the current bit |
| is_rx | input | 1 | Node is the receiver of the current frame |
| req_en | input | 1 | Enable for request overloads after mailbox reception |
| mbox_rx_done | input | 1 | Pulse: a message was stored in a mailbox |
| bus_off | input | 1 | Node is bus-off |
| ctrl_en | input | 1 | Controller enabled |
| err_inc_rx_req | input | 1 | Receive error counter increment request |
| err_inc_tx_req | input | 1 | Transmit error counter increment request |
| ovl_start | output | 1 | One-cycle pulse: overload flag starts with this bit |
| ovl_active | output | 1 | Overload flag is being driven |
| err_inc_rx | output | 1 | Gated receive error counter increment |
| err_inc_tx | output | 1 | Gated transmit error counter increment |

## Verification
The bench builds the block with FLAG_BITS set to 3. This keeps each overload flag short, so that the last flag bit is reached in every scenario. It also means that a trigger placed on the first flag bit and error requests raised during the flag are checked against the exact bit where ovl_active falls. With this setting, all seven position codes, both node roles, the request path with the enable set and clear, and both ways of dropping a pending overload can be covered in one short run.

// File: rtl/can_ovld_trigger.sv
module can_ovld_trigger #(
  parameter int FLAG_BITS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_pt,
  input  logic       bit_start,
  input  logic       rx_bit,
  input  logic [2:0] pos,
  input  logic       is_rx,
  input  logic       req_en,
  input  logic       mbox_rx_done,
  input  logic       bus_off,
  input  logic       ctrl_en,
  input  logic       err_inc_rx_req,
  input  logic       err_inc_tx_req,
  output logic       ovl_start,
  output logic       ovl_active,
  output logic       err_inc_rx,
  output logic       err_inc_tx
);
  localparam int CW = (FLAG_BITS > 1) ? $clog2(FLAG_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLAG_BITS - 1);
  localparam logic [2:0] P_EOF_LAST = 3'd1;
  localparam logic [2:0] P_INT1     = 3'd2;
  localparam logic [2:0] P_INT2     = 3'd3;
  localparam logic [2:0] P_INT3     = 3'd4;
  localparam logic [2:0] P_ERRDEL   = 3'd5;
  localparam logic [2:0] P_OVLDEL   = 3'd6;

  logic          armed, req_pend;
  logic [CW-1:0] cnt;

  wire can_run   = ctrl_en & ~bus_off;
  wire dom       = ~rx_bit;
  wire react_hit = dom & ((pos == P_INT1) | (pos == P_INT2) |
                          ((pos == P_EOF_LAST) & is_rx) |
                          (pos == P_ERRDEL) | (pos == P_OVLDEL));
  wire req_hit   = req_pend & (pos == P_EOF_LAST);
  wire arm_now   = sample_pt & can_run & ~ovl_active & (react_hit | req_hit);

  assign ovl_start  = bit_start & armed & can_run;
  wire   inhibit    = ovl_start | ovl_active;
  assign err_inc_rx = err_inc_rx_req & ~inhibit;
  assign err_inc_tx = err_inc_tx_req & ~inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      req_pend   <= 1'b0;
      ovl_active <= 1'b0;
      cnt        <= '0;
    end else if (!can_run) begin
      armed      <= 1'b0;
      req_pend   <= 1'b0;
      ovl_active <= 1'b0;
      cnt        <= '0;
    end else begin
      if (mbox_rx_done && req_en) req_pend <= 1'b1;
      if (arm_now) armed <= 1'b1;
      if (ovl_start) begin
        armed      <= 1'b0;
        req_pend   <= 1'b0;
        ovl_active <= 1'b1;
        cnt        <= '0;
      end else if (ovl_active && bit_start) begin
        if (cnt == LAST) ovl_active <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_start |=> !ovl_start);

  a_r8_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_start && can_run) |=> ovl_active);

  a_r9_no_count_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_active |-> (!err_inc_rx && !err_inc_tx));

  a_r10_drop_on_off: assert property (@(posedge clk) disable iff (!rst_n)
    !can_run |=> !ovl_start);

  a_r4_third_inter_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && pos == P_INT3 && !armed) |=> !armed);

  a_r8_no_rearm_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_active && !armed) |=> !armed);
endmodule

// File: tb/test_can_ovld_trigger.sv
module test_can_ovld_trigger;
  localparam int FB = 3;
  logic clk = 0, rst_n = 0;
  logic sample_pt = 0, bit_start = 0, rx_bit = 1, is_rx = 0, req_en = 0;
  logic mbox_rx_done = 0, bus_off = 0, ctrl_en = 1;
  logic err_inc_rx_req = 0, err_inc_tx_req = 0;
  logic [2:0] pos = 3'd0;
  logic ovl_start, ovl_active, err_inc_rx, err_inc_tx;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_ovld_trigger #(.FLAG_BITS(FB)) i_can_ovld_trigger (
    .clk(clk), .rst_n(rst_n), .sample_pt(sample_pt), .bit_start(bit_start),
    .rx_bit(rx_bit), .pos(pos), .is_rx(is_rx), .req_en(req_en),
    .mbox_rx_done(mbox_rx_done), .bus_off(bus_off), .ctrl_en(ctrl_en),
    .err_inc_rx_req(err_inc_rx_req), .err_inc_tx_req(err_inc_tx_req),
    .ovl_start(ovl_start), .ovl_active(ovl_active),
    .err_inc_rx(err_inc_rx), .err_inc_tx(err_inc_tx));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kill: 0 none, 1 bus_off pulse, 2 ctrl_en low, between sample point and boundary
  task automatic do_bit(input logic [2:0] p, input logic lvl, input bit sp,
                        input int kill, input bit exp_start, input string tag);
    @(negedge clk); pos = p; rx_bit = lvl; sample_pt = sp;
    @(negedge clk); sample_pt = 0;
    if (kill == 1) bus_off = 1;
    if (kill == 2) ctrl_en = 0;
    @(negedge clk); bus_off = 0; ctrl_en = 1; bit_start = 1;
    #1 check(ovl_start == exp_start, tag, ovl_start, exp_start);
    @(negedge clk); bit_start = 0;
    #1 check(ovl_start == 0, "R7 pulse width", ovl_start, 0);
  endtask

  task automatic run_flag(input string tag);
    check(ovl_active == 1, {tag, " R8 flag rises"}, ovl_active, 1);
    err_inc_rx_req = 1; err_inc_tx_req = 1;
    #1 check(err_inc_rx == 0 && err_inc_tx == 0, "R9 inhibit", err_inc_rx + err_inc_tx, 0);
    for (int i = 0; i < FB; i++) begin
      do_bit((i == 0) ? 3'd2 : 3'd0, 1'b0, 1'b1, 0, 1'b0, "R8 no trigger in flag");
      check(ovl_active == (i < FB - 1), "R8 flag length", ovl_active, i < FB - 1);
    end
    check(err_inc_rx == 1 && err_inc_tx == 1, "R9 pass-through", err_inc_rx + err_inc_tx, 2);
    err_inc_rx_req = 0; err_inc_tx_req = 0;
    do_bit(3'd0, 1'b1, 1'b1, 0, 1'b0, "R8 flag over");
  endtask

  task automatic pulse_mbox();
    @(negedge clk); mbox_rx_done = 1;
    @(negedge clk); mbox_rx_done = 0;
  endtask

  task automatic t_reset();
    check(ovl_start == 0 && ovl_active == 0 && err_inc_rx == 0 && err_inc_tx == 0,
          "R11 reset", ovl_start + ovl_active + err_inc_rx + err_inc_tx, 0);
  endtask

  task automatic t_intermission();
    do_bit(3'd2, 1'b0, 1'b1, 0, 1'b1, "R1 int1 R6"); run_flag("R1");
    do_bit(3'd3, 1'b0, 1'b1, 0, 1'b1, "R1 int2");    run_flag("R1");
    do_bit(3'd4, 1'b0, 1'b1, 0, 1'b0, "R4 int3");
    do_bit(3'd0, 1'b1, 1'b1, 0, 1'b0, "R4 no late start");
    do_bit(3'd2, 1'b0, 1'b0, 0, 1'b0, "R7 no sample point");
    do_bit(3'd2, 1'b1, 1'b1, 0, 1'b0, "R1 recessive quiet");
  endtask

  task automatic t_eof();
    is_rx = 1; do_bit(3'd1, 1'b0, 1'b1, 0, 1'b1, "R2 receiver"); run_flag("R2");
    is_rx = 0; do_bit(3'd1, 1'b0, 1'b1, 0, 1'b0, "R2 transmitter");
    do_bit(3'd0, 1'b1, 1'b1, 0, 1'b0, "R2 transmitter later");
  endtask

  task automatic t_delim();
    is_rx = 0; do_bit(3'd5, 1'b0, 1'b1, 0, 1'b1, "R3 err delim tx"); run_flag("R3");
    is_rx = 1; do_bit(3'd6, 1'b0, 1'b1, 0, 1'b1, "R3 ovl delim rx"); run_flag("R3");
    is_rx = 0; do_bit(3'd6, 1'b0, 1'b1, 0, 1'b1, "R3 ovl delim tx R6"); run_flag("R3");
  endtask

  task automatic t_request();
    req_en = 1; pulse_mbox();
    do_bit(3'd0, 1'b1, 1'b1, 0, 1'b0, "R5 wait for eof");
    do_bit(3'd1, 1'b1, 1'b1, 0, 1'b1, "R5 request start"); run_flag("R5");
    do_bit(3'd1, 1'b1, 1'b1, 0, 1'b0, "R5 request consumed");
    req_en = 0; pulse_mbox();
    do_bit(3'd1, 1'b1, 1'b1, 0, 1'b0, "R5 disabled");
  endtask

  task automatic t_drop();
    req_en = 1; pulse_mbox();
    @(negedge clk); bus_off = 1; @(negedge clk); bus_off = 0;
    do_bit(3'd1, 1'b1, 1'b1, 0, 1'b0, "R10 request dropped by bus-off");
    pulse_mbox();
    do_bit(3'd1, 1'b1, 1'b1, 2, 1'b0, "R10 armed request dropped by disable");
    req_en = 0;
    do_bit(3'd2, 1'b0, 1'b1, 1, 1'b0, "R10 reactive dropped by bus-off");
    do_bit(3'd3, 1'b0, 1'b1, 2, 1'b0, "R10 reactive dropped by disable");
    do_bit(3'd2, 1'b0, 1'b1, 0, 1'b1, "R10 recovers"); run_flag("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_intermission();
    t_eof();
    t_delim();
    t_request();
    t_drop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule